// File: doc/BRIEF.md
# Clock Source Start/Stop Controller

This peripheral switches a high-frequency and a low-frequency clock source on and off in response to one-shot task triggers. A task can come from a write on a simple 32-bit register bus, or from a pulse on one of 256 event channels that the task subscribes to. Each start raises a request toward an oscillator model and waits for that model's ready input. When ready arrives, the block sets a running state bit and records a started event. The event can also go out as a one-cycle pulse on a configurable channel.

For the low-frequency clock, a source select register is sampled at the moment a start task fires. The sampled value is kept in a read-only copy, and the copy alone decides which source the oscillator model is asked for. Software may later change the select register without disturbing the clock that is already running. Each source also has a sticky flag that shows a start has been requested at least once. One interrupt enable word can be reached through three views: a plain read/write view, a write-1-to-set view and a write-1-to-clear view. A read-only pending view gives the AND of each event flag with its enable bit. The interrupt line is the OR of the pending bits.

Top module: `clkctl_top`

## Requirements
- R1: After reset, both requests, `irq` and `chan_out` are 0. The source select (0x518), the source copy (0x41C) and the low-frequency status (0x418) all read 1. Every other mapped register reads 0.
- R2: A bus write to 0x000 with bit 0 set raises `hf_req` at the edge that samples the write. The same edge sets bit 0 of 0x40C, which shows the crystal-derived source is requested. A write with bit 0 clear does nothing.
- R3: The first edge that samples a ready input while its clock is starting sets that clock's event flag (high-frequency at 0x100, low-frequency at 0x104) and its status bit 16. Ready held high later produces no further event.
- R4: A stop task (high-frequency at 0x004, low-frequency at 0x00C, bit 0) drops the request and clears the clock's status bit 16 at the edge that samples it. A stop that comes before ready cancels the start, and no event follows. A stop wins over a start in the same cycle.
- R5: Bits 1:0 of the source select register at 0x518 are 1 for RC and 2 for crystal, and the register resets to 1. The `lf_src_sel` output is taken from the copy, with the reserved value 0 driven out as 1 (RC).
- R6: A low-frequency start (0x008) copies the select value into 0x41C and into bits 1:0 of 0x418. A later write to 0x518 does not change 0x41C or `lf_src_sel` until the next start.
- R7: Bit 0 of the run flags (high-frequency at 0x408, low-frequency at 0x414) is set by a start task and stays set through stop tasks.
- R8: The event flags can be read and written through bit 0. A write of 0 clears the flag and a write of 1 sets it. A flag being generated wins over a write in the same cycle.
- R9: Interrupt enable bit 0 covers the high-frequency event and bit 1 the low-frequency event. A write to 0x300 loads the enable, a write to 0x304 sets the bits written as 1, and a write to 0x308 clears the bits written as 1. All three offsets read the same 2-bit enable.
- R10: The pending register at 0x30C reads event flag AND enable for each bit. `irq` is the OR of the pending bits and follows them in the same cycle.
- R11: The subscribe registers are at 0x080 (high-frequency start), 0x084 (high-frequency stop), 0x088 (low-frequency start) and 0x08C (low-frequency stop). Each holds the channel index in bits 7:0 and an enable in bit 31. A pulse on `chan_in[index]` fires the task only while the enable is 1.
- R12: The publish registers are at 0x180 (high-frequency) and 0x184 (low-frequency), with the same field layout as the subscribe registers. When an enabled event is generated, `chan_out[index]` is high for exactly the cycle after the generating edge.
- R13: Read data appears on `bus_rdata` one cycle after the read request and holds until the next read. The write-only task offsets and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chan_in | input | 256 | Event channel pulses into subscribed tasks |
| chan_out | output | 256 | Event channel pulses from published events |
| hf_req | output | 1 | Request to the high-frequency oscillator |
| hf_rdy | input | 1 | High-frequency oscillator ready |
| lf_req | output | 1 | Request to the low-frequency oscillator |
| lf_rdy | input | 1 | Low-frequency oscillator ready |
| lf_src_sel | output | 2 | Low-frequency source asked for (1 RC, 2 crystal) |
| irq | output | 1 | Interrupt line |

## Verification
A task, a configuration write or a ready input takes effect at the rising edge that samples it. So `hf_req`, `lf_req`, `lf_src_sel` and `irq` are valid in the half cycle right after that edge, and a published pulse on `chan_out` is high only for the cycle that follows. Register reads return their data one edge after the request, and the data shows the state from before that edge. For this reason the bench reads status only after the edge that made the change has passed. The bench drives every input on a falling edge and samples outputs on the next falling edge. It holds ready high for several extra cycles to show that no second event comes.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    OSC_OFF      = 2'd0,
    OSC_STARTING = 2'd1,
    OSC_RUNNING  = 2'd2
  } osc_state_e;

  localparam int N_TASK = 4;
  localparam int N_EVT  = 2;

  // task order inside every task vector: start/stop pairs per clock
  localparam int TK_HF_START = 0;
  localparam int TK_HF_STOP  = 1;
  localparam int TK_LF_START = 2;
  localparam int TK_LF_STOP  = 3;

  localparam int unsigned OFF_TASK_BASE = 32'h000;
  localparam int unsigned OFF_SUB_BASE  = 32'h080;
  localparam int unsigned OFF_EVT_BASE  = 32'h100;
  localparam int unsigned OFF_PUB_BASE  = 32'h180;
  localparam int unsigned OFF_IEN_RW    = 32'h300;
  localparam int unsigned OFF_IEN_SET   = 32'h304;
  localparam int unsigned OFF_IEN_CLR   = 32'h308;
  localparam int unsigned OFF_IPEND     = 32'h30C;
  localparam int unsigned OFF_HF_RAN    = 32'h408;
  localparam int unsigned OFF_HF_STAT   = 32'h40C;
  localparam int unsigned OFF_LF_RAN    = 32'h414;
  localparam int unsigned OFF_LF_STAT   = 32'h418;
  localparam int unsigned OFF_LF_COPY   = 32'h41C;
  localparam int unsigned OFF_LF_SEL    = 32'h518;

  localparam logic [1:0] LF_SRC_RESERVED = 2'd0;
  localparam logic [1:0] LF_SRC_RC       = 2'd1;
  localparam logic [1:0] LF_SRC_XTAL     = 2'd2;

  // enable in bit 31, channel index zero-extended below it
  function automatic logic [31:0] hook_word(input logic en, input logic [30:0] idx);
    return {en, idx};
  endfunction

  // reserved source code is served by the RC oscillator
  function automatic logic [1:0] lf_effective(input logic [1:0] s);
    return (s == LF_SRC_RESERVED) ? LF_SRC_RC : s;
  endfunction

endpackage

// File: rtl/clkctl_osc_fsm.sv
module clkctl_osc_fsm
  import clkctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  input  logic rdy_i,
  output logic req_o,
  output logic running_o,
  output logic fire_o,
  output logic ran_o
);

  osc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (stop_i) begin
      st_d = OSC_OFF;
    end else begin
      case (st_q)
        OSC_OFF:      if (start_i) st_d = OSC_STARTING;
        OSC_STARTING: if (rdy_i)   st_d = OSC_RUNNING;
        default:      st_d = st_q;
      endcase
    end
  end

  // started event: first ready seen while starting, unless cancelled
  assign fire_o    = (st_q == OSC_STARTING) && rdy_i && !stop_i;
  assign req_o     = (st_q != OSC_OFF);
  assign running_o = (st_q == OSC_RUNNING);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= OSC_OFF;
      ran_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_i) ran_o <= 1'b1;
    end
  end

endmodule

// File: rtl/clkctl_evt_hub.sv
module clkctl_evt_hub #(
  parameter  int CH_W  = 8,
  parameter  int N_SUB = 4,
  parameter  int N_PUB = 2,
  localparam int N_CH  = 1 << CH_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CH-1:0]             chan_in,
  input  logic [N_SUB-1:0]            sub_en,
  input  logic [N_SUB-1:0][CH_W-1:0]  sub_idx,
  output logic [N_SUB-1:0]            task_hit,
  input  logic [N_PUB-1:0]            pub_en,
  input  logic [N_PUB-1:0][CH_W-1:0]  pub_idx,
  input  logic [N_PUB-1:0]            pub_fire,
  output logic [N_CH-1:0]             chan_out
);

  logic [N_CH-1:0] out_d;

  generate
    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
      assign task_hit[g] = sub_en[g] & chan_in[sub_idx[g]];
    end
  endgenerate

  always_comb begin
    out_d = '0;
    for (int p = 0; p < N_PUB; p++) begin
      if (pub_en[p] && pub_fire[p]) out_d[pub_idx[p]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chan_out <= '0;
    else     chan_out <= out_d;
  end

endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CH_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic [N_TASK-1:0]           task_o,
  input  logic [N_EVT-1:0]            fire_i,
  input  logic [N_EVT-1:0]            run_i,
  input  logic [N_EVT-1:0]            ran_i,
  input  logic                        hf_req_i,
  input  logic                        lf_start_i,
  output logic [N_TASK-1:0]           sub_en_o,
  output logic [N_TASK-1:0][CH_W-1:0] sub_idx_o,
  output logic [N_EVT-1:0]            pub_en_o,
  output logic [N_EVT-1:0][CH_W-1:0]  pub_idx_o,
  output logic [1:0]                  lf_copy_o,
  output logic                        irq_o
);

  logic             wr, rd;
  logic [N_EVT-1:0] evt_q, ien_q;
  logic [1:0]       lf_sel_q;
  logic [31:0]      rd_mux;
  logic             unused_wbits;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;
  assign unused_wbits = ^bus_wdata[30:CH_W];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == off[ADDR_W-1:0];
  endfunction

  always_comb begin
    for (int t = 0; t < N_TASK; t++) begin
      task_o[t] = wr && bus_wdata[0] && hit(bus_addr, OFF_TASK_BASE + unsigned'(4 * t));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_en_o  <= '0;
      sub_idx_o <= '0;
      pub_en_o  <= '0;
      pub_idx_o <= '0;
      evt_q     <= '0;
      ien_q     <= '0;
      lf_sel_q  <= LF_SRC_RC;
      lf_copy_o <= LF_SRC_RC;
      bus_rdata <= '0;
    end else begin
      for (int t = 0; t < N_TASK; t++) begin
        if (wr && hit(bus_addr, OFF_SUB_BASE + unsigned'(4 * t))) begin
          sub_en_o[t]  <= bus_wdata[31];
          sub_idx_o[t] <= bus_wdata[CH_W-1:0];
        end
      end
      for (int e = 0; e < N_EVT; e++) begin
        if (wr && hit(bus_addr, OFF_PUB_BASE + unsigned'(4 * e))) begin
          pub_en_o[e]  <= bus_wdata[31];
          pub_idx_o[e] <= bus_wdata[CH_W-1:0];
        end
        if (fire_i[e])
          evt_q[e] <= 1'b1;
        else if (wr && hit(bus_addr, OFF_EVT_BASE + unsigned'(4 * e)))
          evt_q[e] <= bus_wdata[0];
      end
      if (wr && hit(bus_addr, OFF_IEN_RW))
        ien_q <= bus_wdata[N_EVT-1:0];
      else if (wr && hit(bus_addr, OFF_IEN_SET))
        ien_q <= ien_q | bus_wdata[N_EVT-1:0];
      else if (wr && hit(bus_addr, OFF_IEN_CLR))
        ien_q <= ien_q & ~bus_wdata[N_EVT-1:0];
      if (wr && hit(bus_addr, OFF_LF_SEL)) lf_sel_q <= bus_wdata[1:0];
      if (lf_start_i) lf_copy_o <= lf_sel_q;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < N_TASK; t++) begin
      if (hit(bus_addr, OFF_SUB_BASE + unsigned'(4 * t)))
        rd_mux = hook_word(sub_en_o[t], 31'(sub_idx_o[t]));
    end
    for (int e = 0; e < N_EVT; e++) begin
      if (hit(bus_addr, OFF_PUB_BASE + unsigned'(4 * e)))
        rd_mux = hook_word(pub_en_o[e], 31'(pub_idx_o[e]));
      if (hit(bus_addr, OFF_EVT_BASE + unsigned'(4 * e)))
        rd_mux = 32'(evt_q[e]);
    end
    if (hit(bus_addr, OFF_IEN_RW) || hit(bus_addr, OFF_IEN_SET) || hit(bus_addr, OFF_IEN_CLR))
      rd_mux = 32'(ien_q);
    if (hit(bus_addr, OFF_IPEND))   rd_mux = 32'(evt_q & ien_q);
    if (hit(bus_addr, OFF_HF_RAN))  rd_mux = 32'(ran_i[0]);
    if (hit(bus_addr, OFF_LF_RAN))  rd_mux = 32'(ran_i[1]);
    if (hit(bus_addr, OFF_HF_STAT)) rd_mux = {15'd0, run_i[0], 15'd0, hf_req_i};
    if (hit(bus_addr, OFF_LF_STAT)) rd_mux = {15'd0, run_i[1], 14'd0, lf_copy_o};
    if (hit(bus_addr, OFF_LF_COPY)) rd_mux = 32'(lf_copy_o);
    if (hit(bus_addr, OFF_LF_SEL))  rd_mux = 32'(lf_sel_q);
  end

  assign irq_o = |(evt_q & ien_q);

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter  int ADDR_W = 12,
  parameter  int CH_W   = 8,
  localparam int N_CH   = 1 << CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_CH-1:0]   chan_in,
  output logic [N_CH-1:0]   chan_out,
  output logic              hf_req,
  input  logic              hf_rdy,
  output logic              lf_req,
  input  logic              lf_rdy,
  output logic [1:0]        lf_src_sel,
  output logic              irq
);

  logic [N_TASK-1:0]           task_bus, task_hit, task_v;
  logic [N_TASK-1:0]           sub_en;
  logic [N_TASK-1:0][CH_W-1:0] sub_idx;
  logic [N_EVT-1:0]            pub_en;
  logic [N_EVT-1:0][CH_W-1:0]  pub_idx;
  logic [N_EVT-1:0]            rdy_v, req_v, run_v, fire_v, ran_v;
  logic [1:0]                  lf_copy;

  assign task_v = task_bus | task_hit;
  assign rdy_v  = {lf_rdy, hf_rdy};

  generate
    for (genvar c = 0; c < N_EVT; c++) begin : g_osc
      clkctl_osc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (task_v[2*c]),
        .stop_i    (task_v[2*c+1]),
        .rdy_i     (rdy_v[c]),
        .req_o     (req_v[c]),
        .running_o (run_v[c]),
        .fire_o    (fire_v[c]),
        .ran_o     (ran_v[c])
      );
    end
  endgenerate

  clkctl_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .task_o     (task_bus),
    .fire_i     (fire_v),
    .run_i      (run_v),
    .ran_i      (ran_v),
    .hf_req_i   (req_v[0]),
    .lf_start_i (task_v[TK_LF_START]),
    .sub_en_o   (sub_en),
    .sub_idx_o  (sub_idx),
    .pub_en_o   (pub_en),
    .pub_idx_o  (pub_idx),
    .lf_copy_o  (lf_copy),
    .irq_o      (irq)
  );

  clkctl_evt_hub #(.CH_W(CH_W), .N_SUB(N_TASK), .N_PUB(N_EVT)) u_hub (
    .clk      (clk),
    .rst      (rst),
    .chan_in  (chan_in),
    .sub_en   (sub_en),
    .sub_idx  (sub_idx),
    .task_hit (task_hit),
    .pub_en   (pub_en),
    .pub_idx  (pub_idx),
    .pub_fire (fire_v),
    .chan_out (chan_out)
  );

  assign hf_req     = req_v[0];
  assign lf_req     = req_v[1];
  assign lf_src_sel = lf_effective(lf_copy);

endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker
  import clkctl_pkg::*;
#(
  parameter  int CH_W = 8,
  localparam int N_CH = 1 << CH_W
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CH-1:0]   chan_out,
  input logic              hf_req,
  input logic              lf_req,
  input logic [1:0]        lf_src_sel,
  input logic [N_TASK-1:0] task_v,
  input logic [N_EVT-1:0]  fire_v
);

  // R1: leaving reset, the block is idle
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hf_req && !lf_req && chan_out == '0));

  // R2: a request only rises after a start task
  assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hf_req) |-> $past(task_v[TK_HF_START]));

  // R3: one started event per start
  assert_hf_evt_once_R3: assert property (@(posedge clk) disable iff (rst)
    fire_v[0] |=> !fire_v[0]);
  assert_lf_evt_once_R3: assert property (@(posedge clk) disable iff (rst)
    fire_v[1] |=> !fire_v[1]);

  // R4: stop drops the request
  assert_hf_stop_R4: assert property (@(posedge clk) disable iff (rst)
    task_v[TK_HF_STOP] |=> !hf_req);
  assert_lf_stop_R4: assert property (@(posedge clk) disable iff (rst)
    task_v[TK_LF_STOP] |=> !lf_req);

  // R5: reserved code never reaches the oscillator
  assert_src_valid_R5: assert property (@(posedge clk) disable iff (rst)
    lf_src_sel != 2'd0);

  // R6: source seen by the oscillator changes only on a start
  assert_copy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !task_v[TK_LF_START] |=> $stable(lf_src_sel));

  // R12: at most one channel pulse per event
  assert_pub_sparse_R12: assert property (@(posedge clk) disable iff (rst)
    $countones(chan_out) <= N_EVT);

endmodule

bind clkctl_top clkctl_checker #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chan_out   (chan_out),
  .hf_req     (hf_req),
  .lf_req     (lf_req),
  .lf_src_sel (lf_src_sel),
  .task_v     (task_v),
  .fire_v     (fire_v)
);

// File: tb/clkctl_top_tb.sv
module clkctl_top_tb;

  localparam int ADDR_W = 12;
  localparam int CH_W   = 8;
  localparam int N_CH   = 1 << CH_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [N_CH-1:0]   chan_in = '0;
  logic [N_CH-1:0]   chan_out;
  logic              hf_req, lf_req, irq;
  logic              hf_rdy = 1'b0;
  logic              lf_rdy = 1'b0;
  logic [1:0]        lf_src_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkctl_top #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_dut (
    .clk, .rst, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .chan_in, .chan_out, .hf_req, .hf_rdy, .lf_req, .lf_rdy, .lf_src_sel, .irq
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // all drivers are entered and left at a falling edge
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; chan_in = '0;
    hf_rdy = 1'b0; lf_rdy = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, $sformatf("read %0h", a), v, exp);
  endtask

  task automatic pulse_ch(input int idx);
    chan_in[idx] = 1'b1;
    @(negedge clk);
    chan_in = '0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1", "hf_req", 32'(hf_req), 0);
    chk("R1", "lf_req", 32'(lf_req), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "chan_out busy", 32'(chan_out != '0), 0);
    chk("R5", "lf_src_sel", 32'(lf_src_sel), 1);
    rd_chk("R1", 12'h518, 1);
    rd_chk("R1", 12'h41C, 1);
    rd_chk("R1", 12'h418, 1);
    rd_chk("R1", 12'h40C, 0);
    rd_chk("R1", 12'h408, 0);
    rd_chk("R1", 12'h300, 0);
    rd_chk("R1", 12'h080, 0);
    rd_chk("R1", 12'h180, 0);
  endtask

  task automatic test_hf_start();
    do_reset();
    bus_wr(12'h000, 32'h2);
    chk("R2", "hf_req after bit0=0", 32'(hf_req), 0);
    rd_chk("R2", 12'h408, 0);
    bus_wr(12'h000, 32'h1);
    chk("R2", "hf_req after start", 32'(hf_req), 1);
    rd_chk("R7", 12'h408, 1);
    rd_chk("R2", 12'h40C, 32'h1);
    rd_chk("R3", 12'h100, 0);
    bus_wr(12'h304, 32'h1);
    chk("R10", "irq before event", 32'(irq), 0);
    hf_rdy = 1'b1;
    @(negedge clk);
    chk("R10", "irq after event", 32'(irq), 1);
    rd_chk("R3", 12'h100, 1);
    rd_chk("R3", 12'h40C, 32'h0001_0001);
    rd_chk("R10", 12'h30C, 1);
    bus_wr(12'h100, 32'h0);
    rd_chk("R8", 12'h100, 0);
    chk("R10", "irq after clear", 32'(irq), 0);
    repeat (3) @(negedge clk);
    rd_chk("R3", 12'h100, 0);
  endtask

  task automatic test_stop();
    do_reset();
    bus_wr(12'h000, 32'h1);
    bus_wr(12'h004, 32'h1);
    chk("R4", "hf_req after early stop", 32'(hf_req), 0);
    hf_rdy = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R4", 12'h100, 0);
    rd_chk("R4", 12'h40C, 0);
    rd_chk("R7", 12'h408, 1);
    bus_wr(12'h000, 32'h1);
    @(negedge clk);
    rd_chk("R3", 12'h40C, 32'h0001_0001);
    bus_wr(12'h004, 32'h1);
    rd_chk("R4", 12'h40C, 0);
    rd_chk("R7", 12'h408, 1);
    chk("R4", "hf_req after stop", 32'(hf_req), 0);
  endtask

  task automatic test_lf_src();
    do_reset();
    bus_wr(12'h518, 32'h2);
    chk("R6", "lf_src_sel before start", 32'(lf_src_sel), 1);
    rd_chk("R6", 12'h41C, 1);
    bus_wr(12'h008, 32'h1);
    chk("R6", "lf_src_sel after start", 32'(lf_src_sel), 2);
    rd_chk("R6", 12'h41C, 2);
    rd_chk("R6", 12'h418, 2);
    bus_wr(12'h518, 32'h0);
    rd_chk("R5", 12'h518, 0);
    rd_chk("R6", 12'h41C, 2);
    chk("R6", "lf_src_sel held", 32'(lf_src_sel), 2);
    bus_wr(12'h008, 32'h1);
    rd_chk("R6", 12'h41C, 0);
    chk("R5", "reserved maps to RC", 32'(lf_src_sel), 1);
    lf_rdy = 1'b1;
    @(negedge clk);
    rd_chk("R3", 12'h418, 32'h0001_0000);
    rd_chk("R3", 12'h104, 1);
    rd_chk("R7", 12'h414, 1);
    bus_wr(12'h00C, 32'h1);
    rd_chk("R4", 12'h418, 0);
    rd_chk("R7", 12'h414, 1);
    chk("R4", "lf_req after stop", 32'(lf_req), 0);
  endtask

  task automatic test_inten();
    do_reset();
    bus_wr(12'h300, 32'h3);
    rd_chk("R9", 12'h304, 3);
    rd_chk("R9", 12'h308, 3);
    bus_wr(12'h308, 32'h1);
    rd_chk("R9", 12'h300, 2);
    bus_wr(12'h304, 32'h1);
    rd_chk("R9", 12'h300, 3);
    bus_wr(12'h300, 32'hFFFF_FFFC);
    rd_chk("R9", 12'h304, 0);
  endtask

  task automatic test_pend();
    do_reset();
    bus_wr(12'h104, 32'h1);
    rd_chk("R8", 12'h104, 1);
    chk("R10", "irq masked", 32'(irq), 0);
    rd_chk("R10", 12'h30C, 0);
    bus_wr(12'h304, 32'h2);
    chk("R10", "irq enabled", 32'(irq), 1);
    rd_chk("R10", 12'h30C, 2);
    bus_wr(12'h304, 32'h1);
    rd_chk("R10", 12'h30C, 2);
    bus_wr(12'h104, 32'h0);
    chk("R10", "irq after clear", 32'(irq), 0);
    rd_chk("R10", 12'h30C, 0);
  endtask

  task automatic test_subscribe();
    do_reset();
    bus_wr(12'h080, 32'h8000_0007);
    rd_chk("R11", 12'h080, 32'h8000_0007);
    pulse_ch(6);
    chk("R11", "wrong channel", 32'(hf_req), 0);
    pulse_ch(7);
    chk("R11", "matched channel", 32'(hf_req), 1);
    bus_wr(12'h088, 32'h0000_0009);
    pulse_ch(9);
    chk("R11", "disabled subscribe", 32'(lf_req), 0);
    rd_chk("R11", 12'h414, 0);
    bus_wr(12'h088, 32'h8000_0009);
    pulse_ch(9);
    chk("R11", "enabled subscribe", 32'(lf_req), 1);
    bus_wr(12'h08C, 32'h8000_0009);
    pulse_ch(9);
    chk("R4", "stop wins over start", 32'(lf_req), 0);
    rd_chk("R7", 12'h414, 1);
  endtask

  task automatic test_publish();
    do_reset();
    bus_wr(12'h180, 32'h8000_0021);
    bus_wr(12'h184, 32'h0000_0022);
    rd_chk("R12", 12'h180, 32'h8000_0021);
    bus_wr(12'h000, 32'h1);
    hf_rdy = 1'b1;
    @(negedge clk);
    chk("R12", "chan_out[33]", 32'(chan_out[33]), 1);
    chk("R12", "pulse count", 32'($countones(chan_out)), 1);
    @(negedge clk);
    chk("R12", "pulse one cycle", 32'(chan_out != '0), 0);
    bus_wr(12'h008, 32'h1);
    lf_rdy = 1'b1;
    @(negedge clk);
    chk("R12", "disabled publish", 32'(chan_out != '0), 0);
    rd_chk("R12", 12'h104, 1);
  endtask

  task automatic test_bus();
    do_reset();
    bus_wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R13", 12'h200, 0);
    bus_wr(12'h000, 32'h1);
    rd_chk("R13", 12'h000, 0);
    rd_chk("R13", 12'h51C, 0);
    rd_chk("R13", 12'h408, 1);
    @(negedge clk);
    chk("R13", "rdata held", bus_rdata, 1);
  endtask

  initial begin
    test_reset();
    test_hf_start();
    test_stop();
    test_lf_src();
    test_inten();
    test_pend();
    test_subscribe();
    test_publish();
    test_bus();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule